// File: doc/BRIEF.md
# Two-Wire Transition-Coded Word-Serial Link

This block carries N-bit words across a two-wire serial channel. One wire, the level wire, always shows the value of the bit being sent. The other wire, the parity wire, flips only when the new bit repeats the level already on the line. As a result every bit moves exactly one wire, and the receiver needs no clock from the sender. The receiver detects a new bit when the exclusive-OR of the two wires changes, and takes the bit from the level wire.

Flow control works per word. When the receiver has gathered a full word, it presents the word for one cycle and flips a single acknowledge wire. The sender sees that acknowledge only after a two-flop synchronizer. It holds off the next word until the flip arrives, and can accept the next word in that same cycle. Both ends are modelled here as logic clocked faster than the bit rate. The receiver also passes the two line wires through a two-flop synchronizer.

Top module: `ledr_link`

## Requirements
- R1: On every line transition, the level wire equals the data bit being sent.
- R2: The parity wire toggles for a bit if and only if that bit equals the level wire's value before the bit, reset level being 0.
- R3: Each bit causes exactly one transition, on exactly one of the two wires, and there are exactly DATA_W transitions per word.
- R4: Bits go out most significant first. Bit DATA_W-1 of the accepted word is the first transition.
- R5: After the last bit arrives, rx_valid is high for exactly one cycle and rx_data equals the accepted word.
- R6: line_ack toggles exactly once per received word, in the same cycle that rx_valid is high, and at no other time.
- R7: tx_ready is low from the cycle after a word is accepted until that word's acknowledge has been observed.
- R8: While the transmitter is idle, or while tx_ready is low, tx_valid and tx_data cause no line transition. Only the tx_data present in the accepting cycle is sent.
- R9: During reset, line_state, line_phase, line_ack and rx_valid are 0 and tx_ready is 1.
- R10: The acknowledge reaches the transmitter through two flops. tx_ready is low in the cycle after rx_valid and high in the second cycle after it, and a word offered in that cycle is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | A word is offered for sending |
| tx_data | input | DATA_W | Word to send |
| tx_ready | output | 1 | Transmitter can accept a word in this cycle |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new word |
| rx_data | output | DATA_W | Last received word |
| line_state | output | 1 | Level wire of the serial line |
| line_phase | output | 1 | Parity wire of the serial line |
| line_ack | output | 1 | Toggle acknowledge, one flip per word |

## Verification
The acknowledge release and the acceptance of the next word can fall in the same cycle. This happens when the transmitter's synchronized acknowledge flips while tx_valid is already held high. The bench provokes it by offering each new word before the previous one is acknowledged, and by scrambling tx_data on every waiting cycle. It judges the result in two ways. A cycle-by-cycle reference model expects tx_ready exactly two cycles after rx_valid. The next transition must then carry the most significant bit of the data present in that cycle.

// File: rtl/ledr_pkg.sv
// Shared types and helpers for the two-wire transition-coded link.
// Assumes nothing beyond a single synthesizable compile unit.
package ledr_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_e;

    // Parity wire value that keeps exactly one wire moving for new_bit.
    function automatic logic next_phase(input logic new_bit,
                                        input logic cur_level,
                                        input logic cur_phase);
        return (new_bit == cur_level) ? ~cur_phase : cur_phase;
    endfunction

endpackage

// File: rtl/ledr_sync2.sv
// Two-flop synchronizer for a WIDTH-bit bus of independent levels.
// Assumes each bit is a slow level or toggle (no multi-bit coherency needed
// beyond what the two-wire code itself guarantees).
module ledr_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    // Capture the asynchronous level and let it settle for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/ledr_tx.sv
// Transmit end: accepts a word, shifts it out MSB first onto the level and
// parity wires (one wire transition per bit, one bit every BIT_TICKS cycles),
// then waits for a toggle on the synchronized acknowledge before the next
// word. Assumes the acknowledge input is asynchronous to clk.
module ledr_tx
    import ledr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              ack_in,
    output logic              wire_level,
    output logic              wire_phase
);

    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int TICK_W = $clog2(BIT_TICKS + 1);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic [TICK_W-1:0] gap;
    logic              ack_sync;
    logic              ack_seen;
    logic              ack_new;
    logic              accept;
    logic              next_bit;
    logic              nphase;

    ledr_sync2 #(.WIDTH(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_in),
        .q     (ack_sync)
    );

    // Decode handshake and the bit about to be driven.
    always_comb begin
        ack_new  = ack_sync ^ ack_seen;
        in_ready = (state == TX_IDLE) || ((state == TX_WAIT) && ack_new);
        accept   = in_valid && in_ready;
        next_bit = (state == TX_SEND) ? shreg[DATA_W-1] : in_data[DATA_W-1];
        nphase   = next_phase(next_bit, wire_level, wire_phase);
    end

    // Sequence words onto the line and track the acknowledge handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            shreg      <= '0;
            bits_left  <= '0;
            gap        <= '0;
            ack_seen   <= 1'b0;
            wire_level <= 1'b0;
            wire_phase <= 1'b0;
        end else begin
            if ((state == TX_WAIT) && ack_new) begin
                ack_seen <= ack_sync;
            end
            case (state)
                TX_IDLE, TX_WAIT: begin
                    if (accept) begin
                        wire_level <= next_bit;
                        wire_phase <= nphase;
                        shreg      <= in_data << 1;
                        bits_left  <= CNT_W'(DATA_W - 1);
                        gap        <= TICK_W'(BIT_TICKS - 1);
                        state      <= TX_SEND;
                    end else if (state == TX_WAIT && ack_new) begin
                        state <= TX_IDLE;
                    end
                end
                TX_SEND: begin
                    if (gap != '0) begin
                        gap <= gap - 1'b1;
                    end else if (bits_left != '0) begin
                        wire_level <= next_bit;
                        wire_phase <= nphase;
                        shreg      <= shreg << 1;
                        bits_left  <= bits_left - 1'b1;
                        gap        <= TICK_W'(BIT_TICKS - 1);
                    end else begin
                        state <= TX_WAIT;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ledr_rx.sv
// Receive end: synchronizes the two line wires, detects each bit as a change
// of level XOR parity, shifts the level in MSB first, and after DATA_W bits
// strobes the word out and toggles the acknowledge once.
// Assumes the line wires change at most once per bit period, slower than clk.
module ledr_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wire_level,
    input  logic              wire_phase,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ack_out
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [1:0]        line_sync;
    logic              lvl_s;
    logic              par_last;
    logic              bit_evt;
    logic              word_done;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shift_next;

    ledr_sync2 #(.WIDTH(2)) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wire_level, wire_phase}),
        .q     (line_sync)
    );

    // Detect a new bit and form the shifted word.
    always_comb begin
        lvl_s      = line_sync[1];
        bit_evt    = (line_sync[1] ^ line_sync[0]) != par_last;
        word_done  = bit_evt && (cnt == CNT_W'(DATA_W - 1));
        shift_next = {shreg[DATA_W-2:0], lvl_s};
    end

    // Collect bits, deliver the word and toggle the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_last  <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            ack_out   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (bit_evt) begin
                par_last <= ~par_last;
                if (word_done) begin
                    out_data  <= shift_next;
                    out_valid <= 1'b1;
                    ack_out   <= ~ack_out;
                    cnt       <= '0;
                    shreg     <= '0;
                end else begin
                    shreg <= shift_next;
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ledr_link.sv
// Top: transmitter and receiver of the two-wire word-serial link joined by
// their line and acknowledge wires, which are also brought out for
// observation. Assumes DATA_W >= 2 and 1 <= BIT_TICKS <= 5, so that the
// transmitter has finished its last bit period before the acknowledge returns.
module ledr_link #(
    parameter int DATA_W    = 8,
    parameter int BIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              line_state,
    output logic              line_phase,
    output logic              line_ack
);

    ledr_tx #(.DATA_W(DATA_W), .BIT_TICKS(BIT_TICKS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid),
        .in_data    (tx_data),
        .in_ready   (tx_ready),
        .ack_in     (line_ack),
        .wire_level (line_state),
        .wire_phase (line_phase)
    );

    ledr_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wire_level (line_state),
        .wire_phase (line_phase),
        .out_valid  (rx_valid),
        .out_data   (rx_data),
        .ack_out    (line_ack)
    );

endmodule

// File: rtl/ledr_link_chk.sv
// Temporal checks on the ports of ledr_link, attached by bind.
module ledr_link_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              line_state,
    input logic              line_phase,
    input logic              line_ack
);

    // R3
    one_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((line_state != $past(line_state)) && (line_phase != $past(line_phase))));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    ack_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ack != $past(line_ack)) |-> rx_valid);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> ($stable(line_state) && $stable(line_phase)));

    // R4
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (line_state == $past(tx_data[DATA_W-1])));

endmodule

bind ledr_link ledr_link_chk #(.DATA_W(DATA_W)) u_ledr_link_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .line_state (line_state),
    .line_phase (line_phase),
    .line_ack   (line_ack)
);

// File: tb/ledr_link_bench.sv
// Bench: drives words, keeps a behavioural model of the line and handshake,
// and compares it with the ports on every clock.
module ledr_link_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_ready;
    logic         rx_valid;
    logic [W-1:0] rx_data;
    logic         line_state;
    logic         line_phase;
    logic         line_ack;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    int received = 0;
    int since = -1;
    bit run_model = 1'b0;
    bit done = 1'b0;
    bit exp_bits[$];
    logic [W-1:0] exp_words[$];
    logic prev_s, prev_p, prev_ack;

    always #2.5 clk = ~clk;

    ledr_link #(.DATA_W(W), .BIT_TICKS(2)) u_ledr_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .line_state (line_state),
        .line_phase (line_phase),
        .line_ack   (line_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Offer a word; optionally scramble the data on every waiting cycle.
    task automatic send_word(input logic [W-1:0] d, input bit noisy);
        logic [W-1:0] sent;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        #1;
        while (!tx_ready) begin
            @(negedge clk);
            if (noisy) tx_data = W'($urandom);
            #1;
        end
        sent = tx_data;
        @(posedge clk);
        for (int i = W - 1; i >= 0; i--) exp_bits.push_back(sent[i]);
        exp_words.push_back(sent);
        accepted++;
    endtask

    task automatic go_idle(input int cycles);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            tx_data = W'($urandom);
            @(negedge clk);
        end
    endtask

    // Reference model, compared every clock.
    always @(negedge clk) begin
        if (run_model) begin
            bit s_chg, p_chg, b;
            logic [W-1:0] w;
            #2;
            s_chg = (line_state != prev_s);
            p_chg = (line_phase != prev_p);
            if (s_chg || p_chg) begin
                check(!(s_chg && p_chg), "R3 one wire per bit", {s_chg, p_chg}, 1);
                if (exp_bits.size() == 0) begin
                    check(1'b0, "R8 transition with no word accepted", 1, 0);
                end else begin
                    b = exp_bits.pop_front();
                    check(line_state == b, "R1 R4 level equals next bit MSB first", line_state, b);
                    check(p_chg == (b == prev_s), "R2 parity toggles on repeat", p_chg, (b == prev_s));
                end
            end
            if (rx_valid) begin
                if (exp_words.size() == 0) begin
                    check(1'b0, "R5 word strobe with nothing sent", rx_data, 0);
                end else begin
                    w = exp_words.pop_front();
                    check(rx_data == w, "R5 received word", rx_data, w);
                    check(exp_bits.size() == 0, "R3 bit count per word", exp_bits.size(), 0);
                end
                received++;
                check(line_ack != prev_ack, "R6 ack toggles with word", line_ack, !prev_ack);
                since = 0;
            end else begin
                check(line_ack == prev_ack, "R6 ack quiet between words", line_ack, prev_ack);
                if (since >= 0) begin
                    since++;
                    if (since == 1)
                        check(!tx_ready, "R10 ready not before sync delay", tx_ready, 0);
                    if (since == 2) begin
                        check(tx_ready, "R10 ready after two-flop sync", tx_ready, 1);
                        since = -1;
                    end
                end
            end
            if (accepted > received)
                check(!tx_ready, "R7 busy while word outstanding", tx_ready, 0);
            prev_s   = line_state;
            prev_p   = line_phase;
            prev_ack = line_ack;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pats [0:7];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hAA; pats[3] = 8'h55;
        pats[4] = 8'h80; pats[5] = 8'h01; pats[6] = 8'h5A; pats[7] = 8'hC3;
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        check(line_state == 1'b0, "R9 reset level wire", line_state, 0);
        check(line_phase == 1'b0, "R9 reset parity wire", line_phase, 0);
        check(line_ack == 1'b0, "R9 reset ack", line_ack, 0);
        check(rx_valid == 1'b0, "R9 reset strobe", rx_valid, 0);
        check(tx_ready == 1'b1, "R9 reset ready", tx_ready, 1);
        prev_s = 1'b0; prev_p = 1'b0; prev_ack = 1'b0;
        rst_n = 1'b1;
        run_model = 1'b1;
        go_idle(20);
        // Separated words with idle gaps.
        for (int i = 0; i < 8; i++) begin
            send_word(pats[i], 1'b0);
            go_idle(30);
        end
        // Back-to-back: valid held so release and accept share a cycle.
        for (int i = 0; i < 40; i++) send_word(W'($urandom), 1'b0);
        // Scrambled data while waiting: only the accepting cycle counts.
        for (int i = 0; i < 30; i++) send_word(W'($urandom), 1'b1);
        go_idle(60);
        check(exp_words.size() == 0, "R5 all words delivered", exp_words.size(), 0);
        check(received == accepted, "R6 one ack per word", received, accepted);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule